// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. A request first probes a small fully associative translation cache keyed by the virtual page number. On a hit the physical page comes straight from the cache and memory is never touched. On a miss the block reads a top-level directory entry and then a second-level table entry through a single word-read memory port. It then returns either the translated address or a page fault that names the level holding the invalid entry.

Only one translation is in flight at a time. A successful walk writes its mapping into the cache, choosing the victim slot round-robin. A fault leaves the cache untouched. Software changes the table base by driving a new `base_addr` and pulsing `flush`. The base is sampled when a request is accepted.

All three data paths use valid/ready rules. A request is held with `req_valid` and its address stays stable until `req_ready` is seen high at a clock edge. `req_ready` is high only when the block is idle. A result holds `rsp_valid` and every response field unchanged until `rsp_ready` is high at an edge. A memory read holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready` is high at an edge. Memory answers with a one-cycle `mem_rsp_valid` pulse and has no ready signal, because at most one read is ever outstanding.

Top module: `xlate_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: On a cache miss the first memory read is at `base + VA[31:22]*4`, using the base sampled when the request was accepted. The second read is at `{dir_entry[31:12], 12'h000} + VA[21:12]*4`. In every entry bit 0 is the valid bit and bits 31:12 are the frame number.
- R3: A successful walk returns `rsp_fault`=0 and `rsp_paddr` = `{table_entry[31:12], VA[11:0]}`. `rsp_vaddr` equals the request address.
- R4: A request whose virtual page is cached issues no memory read. It returns the cached frame joined with `VA[11:0]`.
- R5: A directory entry with bit 0 clear ends the walk after exactly one read. The result has `rsp_fault`=1, `rsp_fault_lvl`=0, `rsp_paddr`=0 and `rsp_vaddr` equal to the faulting address.
- R6: A table entry with bit 0 clear ends the walk after exactly two reads. The result has `rsp_fault`=1, `rsp_fault_lvl`=1 and `rsp_paddr`=0.
- R7: A faulting walk fills no cache entry, so repeating the same address walks memory again.
- R8: A `flush` pulse invalidates every cache entry and returns the replacement pointer to slot 0. Flush wins over a fill in the same cycle.
- R9: Fills go to slots 0, 1, … N-1 and then wrap. After N+1 distinct pages have been filled, the first page misses and the others still hit.
- R10: `req_ready` is low from acceptance until the result is consumed. The response fields stay stable while `rsp_valid` is high and `rsp_ready` is low. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready`.
- R11: A new `base_addr` applied with a flush is used for the directory read of the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| base_addr | input | 32 | Physical address of the directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted at this edge |
| req_vaddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_vaddr | output | 32 | Linear address of this result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_lvl | output | 1 | 0 = directory entry invalid, 1 = table entry invalid |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Entry word |

## Verification
The bench builds the walker with a four-slot cache instead of the default eight. Five distinct page fills are then enough to wrap the round-robin pointer, evict the oldest mapping and show a survivor still hitting. The bench memory model takes a variable latency and can drop `mem_req_ready` on alternate cycles. With those settings the request-hold and single-outstanding rules are exercised on both table levels, alongside a result held back by `rsp_ready`.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_READ_DIR,
    ST_READ_TBL,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } fault_lvl_e;
endpackage

// File: rtl/xw_tlb.sv
// Fully associative page cache with round-robin victim selection.
module xw_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic [ENTRIES-1:0] hit_vec,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_vld;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [IW-1:0]      vptr;
  logic               do_fill;

  assign do_fill = fill_en && !flush;

  // victim pointer: wraps at ENTRIES-1, cleared by flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vptr <= '0;
    end else if (flush) begin
      vptr <= '0;
    end else if (fill_en) begin
      if (vptr == IW'(ENTRIES - 1)) vptr <= '0;
      else                          vptr <= vptr + 1'b1;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = do_fill && (vptr == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_vld[i] <= 1'b0;
      else if (flush) ent_vld[i] <= 1'b0;
      else if (sel)   ent_vld[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[i] <= fill_vpn;
        ent_ppn[i] <= fill_ppn;
      end
    end

    assign hit_vec[i] = ent_vld[i] && (ent_vpn[i] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_ppn = lk_ppn | ent_ppn[i];
    end
  end

  assign lk_hit = |hit_vec;
endmodule

// File: rtl/xw_walk.sv
// Walk sequencer: lookup, directory read, table read, result.
module xw_walk
  import xw_pkg::*;
#(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int VALID_BIT   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           base_addr,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_vaddr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [AW-1:0]           rsp_vaddr,
  output logic [AW-1:0]           rsp_paddr,
  output logic                    rsp_fault,
  output logic                    rsp_fault_lvl,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [AW-1:0]           mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [AW-1:0]           mem_rsp_data,
  output logic [AW-PAGE_BITS-1:0] lk_vpn,
  input  logic                    tlb_hit,
  input  logic [AW-PAGE_BITS-1:0] tlb_ppn,
  output logic                    fill_en,
  output logic [AW-PAGE_BITS-1:0] fill_vpn,
  output logic [AW-PAGE_BITS-1:0] fill_ppn
);
  localparam int PPN_W = AW - PAGE_BITS;
  localparam int ESH   = $clog2(ENTRY_BYTES);

  walk_st_e        state;
  fault_lvl_e      lvl_q;
  logic            sent_q;
  logic [AW-1:0]   va_q;
  logic [AW-1:0]   base_q;
  logic [PPN_W-1:0] frame_q;
  logic [AW-1:0]   pa_q;

  logic [IDX_W-1:0] dir_idx, tbl_idx;
  logic [AW-1:0]    dir_ent_addr, tbl_ent_addr;
  logic [PPN_W-1:0] ent_frame;
  logic             ent_valid, rsp_take, mem_fire;
  logic             unused_ctrl;

  assign dir_idx      = va_q[PAGE_BITS + IDX_W +: IDX_W];
  assign tbl_idx      = va_q[PAGE_BITS +: IDX_W];
  assign dir_ent_addr = base_q + (AW'(dir_idx) << ESH);
  assign tbl_ent_addr = {frame_q, {PAGE_BITS{1'b0}}} + (AW'(tbl_idx) << ESH);

  assign ent_frame   = mem_rsp_data[AW-1 -: PPN_W];
  assign ent_valid   = mem_rsp_data[VALID_BIT];
  assign unused_ctrl = ^mem_rsp_data;
  assign rsp_take    = mem_rsp_valid && sent_q;
  assign mem_fire    = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lvl_q   <= LVL_DIR;
      sent_q  <= 1'b0;
      va_q    <= '0;
      base_q  <= '0;
      frame_q <= '0;
      pa_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            base_q <= base_addr;
            state  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          sent_q <= 1'b0;
          if (tlb_hit) begin
            pa_q  <= {tlb_ppn, va_q[PAGE_BITS-1:0]};
            state <= ST_DONE;
          end else begin
            state <= ST_READ_DIR;
          end
        end
        ST_READ_DIR: begin
          if (mem_fire) sent_q <= 1'b1;
          if (rsp_take) begin
            sent_q <= 1'b0;
            if (ent_valid) begin
              frame_q <= ent_frame;
              state   <= ST_READ_TBL;
            end else begin
              lvl_q <= LVL_DIR;
              state <= ST_FAULT;
            end
          end
        end
        ST_READ_TBL: begin
          if (mem_fire) sent_q <= 1'b1;
          if (rsp_take) begin
            sent_q <= 1'b0;
            if (ent_valid) begin
              pa_q  <= {ent_frame, va_q[PAGE_BITS-1:0]};
              state <= ST_DONE;
            end else begin
              lvl_q <= LVL_TBL;
              state <= ST_FAULT;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = ((state == ST_READ_DIR) || (state == ST_READ_TBL)) && !sent_q;
  assign mem_req_addr  = (state == ST_READ_TBL) ? tbl_ent_addr : dir_ent_addr;
  assign rsp_valid     = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault     = (state == ST_FAULT);
  assign rsp_fault_lvl = (state == ST_FAULT) && (lvl_q == LVL_TBL);
  assign rsp_paddr     = (state == ST_DONE) ? pa_q : '0;
  assign rsp_vaddr     = va_q;

  assign lk_vpn   = va_q[AW-1:PAGE_BITS];
  assign fill_en  = (state == ST_READ_TBL) && rsp_take && ent_valid;
  assign fill_vpn = va_q[AW-1:PAGE_BITS];
  assign fill_ppn = ent_frame;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter int TLB_ENTRIES = 8,
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int VALID_BIT   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_vaddr,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic          rsp_fault_lvl,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);
  localparam int PN_W = AW - PAGE_BITS;

  logic [PN_W-1:0]        lk_vpn, tlb_ppn, fill_vpn, fill_ppn;
  logic                   tlb_hit, fill_en;
  logic [TLB_ENTRIES-1:0] tlb_hit_vec;

  xw_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (PN_W),
    .PPN_W   (PN_W)
  ) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (lk_vpn),
    .lk_hit   (tlb_hit),
    .lk_ppn   (tlb_ppn),
    .hit_vec  (tlb_hit_vec),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn)
  );

  xw_walk #(
    .AW          (AW),
    .PAGE_BITS   (PAGE_BITS),
    .IDX_W       (IDX_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .VALID_BIT   (VALID_BIT)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_addr     (base_addr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_vaddr     (rsp_vaddr),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lk_vpn        (lk_vpn),
    .tlb_hit       (tlb_hit),
    .tlb_ppn       (tlb_ppn),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn)
  );
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
  parameter int ENTRIES   = 8,
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [AW-1:0]      rsp_vaddr,
  input logic [AW-1:0]      rsp_paddr,
  input logic               rsp_fault,
  input logic               rsp_fault_lvl,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [AW-1:0]      mem_req_addr,
  input logic [ENTRIES-1:0] tlb_hit_vec
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_vaddr)
      && $stable(rsp_fault) && $stable(rsp_fault_lvl));

  // R10
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_BITS-1:0] == rsp_vaddr[PAGE_BITS-1:0]);

  // R5
  fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R4
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));
endmodule

bind xlate_walker xlate_walker_chk #(
  .ENTRIES   (TLB_ENTRIES),
  .AW        (AW),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_vaddr     (rsp_vaddr),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_fault_lvl (rsp_fault_lvl),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .tlb_hit_vec   (tlb_hit_vec)
);

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;
  localparam int NENT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] base_addr = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_vaddr, rsp_paddr;
  logic        rsp_fault, rsp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2.5 clk = ~clk;

  xlate_walker #(.TLB_ENTRIES(NENT)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_vaddr(rsp_vaddr),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;

  // sparse memory model
  logic [31:0] mem [int unsigned];
  int          lat = 0;
  bit          slow = 1'b0;
  bit          tgl = 1'b0;
  bit          pend = 1'b0;
  int          lat_cnt = 0;
  logic [31:0] pend_addr = '0;
  int          rd_count = 0;
  logic [31:0] rd_log [4];

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_mem(pend_addr);
          pend = 1'b0;
        end else begin
          lat_cnt--;
        end
      end
      tgl = ~tgl;
      mem_req_ready = slow ? tgl : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend      = 1'b1;
        lat_cnt   = lat;
        pend_addr = mem_req_addr;
        rd_log[rd_count % 4] = mem_req_addr;
        rd_count++;
      end
    end
  end

  // expected entry addresses, per R2
  function automatic logic [31:0] dir_ea(input logic [31:0] b, input logic [31:0] va);
    return b + {20'h0, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] tbl_ea(input logic [19:0] fr, input logic [31:0] va);
    return {fr, 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] g_pa, g_va;
  logic        g_fault, g_lvl;
  int          g_reads;

  task automatic translate(input logic [31:0] va);
    int start;
    start = rd_count;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    g_pa = rsp_paddr; g_va = rsp_vaddr; g_fault = rsp_fault; g_lvl = rsp_fault_lvl;
    g_reads = rd_count - start;
    @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  localparam logic [31:0] VA1 = 32'h1234_5678;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req_ready", {31'h0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_miss_walk();
    mem[dir_ea(base_addr, VA1)] = {20'h00200, 12'h001};
    mem[tbl_ea(20'h00200, VA1)] = {20'hABCDE, 12'h001};
    translate(VA1);
    chk("R2 read count", g_reads, 2);
    chk("R2 dir addr", rd_log[(rd_count-2) % 4], dir_ea(32'h0010_0000, VA1));
    chk("R2 tbl addr", rd_log[(rd_count-1) % 4], tbl_ea(20'h00200, VA1));
    chk("R3 paddr", g_pa, 32'hABCD_E678);
    chk("R3 fault", {31'h0, g_fault}, 0);
    chk("R3 vaddr", g_va, VA1);
  endtask

  task automatic t_hit();
    translate(VA1 ^ 32'h0000_0ABC);
    chk("R4 no reads", g_reads, 0);
    chk("R4 paddr", g_pa, {20'hABCDE, 12'h678 ^ 12'hABC});
  endtask

  task automatic t_dir_fault();
    logic [31:0] va;
    va = 32'h8000_1234;
    translate(va);
    chk("R5 fault", {31'h0, g_fault}, 1);
    chk("R5 level", {31'h0, g_lvl}, 0);
    chk("R5 paddr", g_pa, 0);
    chk("R5 vaddr", g_va, va);
    chk("R5 reads", g_reads, 1);
    translate(va);
    chk("R7 rewalk reads", g_reads, 1);
    chk("R7 still faults", {31'h0, g_fault}, 1);
  endtask

  task automatic t_tbl_fault();
    logic [31:0] va;
    va = 32'h4040_3321;
    mem[dir_ea(base_addr, va)] = {20'h00300, 12'h001};
    mem[tbl_ea(20'h00300, va)] = {20'h77777, 12'h000};
    translate(va);
    chk("R6 fault", {31'h0, g_fault}, 1);
    chk("R6 level", {31'h0, g_lvl}, 1);
    chk("R6 paddr", g_pa, 0);
    chk("R6 reads", g_reads, 2);
    translate(va);
    chk("R7 tbl rewalk", g_reads, 2);
  endtask

  task automatic t_flush();
    translate(VA1);
    chk("R8 pre-flush hit", g_reads, 0);
    pulse_flush();
    translate(VA1);
    chk("R8 post-flush walk", g_reads, 2);
    chk("R8 post-flush paddr", g_pa, 32'hABCD_E678);
  endtask

  task automatic t_rr();
    pulse_flush();
    mem[base_addr + 32'd4] = {20'h00400, 12'h001};
    for (int k = 0; k <= NENT; k++) begin
      logic [31:0] va;
      va = {10'd1, 10'(k), 12'h010};
      mem[tbl_ea(20'h00400, va)] = {20'h10000 + 20'(k), 12'h001};
      translate(va);
      chk("R9 fill walk", g_reads, 2);
    end
    translate({10'd1, 10'd2, 12'h020});
    chk("R9 survivor hit", g_reads, 0);
    chk("R9 survivor paddr", g_pa, {20'h10002, 12'h020});
    translate({10'd1, 10'd0, 12'h030});
    chk("R9 evicted walks", g_reads, 2);
    chk("R9 evicted paddr", g_pa, {20'h10000, 12'h030});
  endtask

  task automatic t_backpressure();
    logic [31:0] va, held;
    va = 32'h0C00_5ABC;
    mem[dir_ea(base_addr, va)] = {20'h00500, 12'h001};
    mem[tbl_ea(20'h00500, va)] = {20'h5A5A5, 12'h001};
    slow = 1'b1; lat = 3; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy", {31'h0, req_ready}, 0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_paddr;
    chk("R10 slow-mem paddr", held, {20'h5A5A5, 12'hABC});
    repeat (5) @(negedge clk);
    chk("R10 rsp held", {31'h0, rsp_valid}, 1);
    chk("R10 paddr stable", rsp_paddr, held);
    chk("R10 not ready while held", {31'h0, req_ready}, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 consumed", {31'h0, rsp_valid}, 0);
    chk("R10 idle again", {31'h0, req_ready}, 1);
    slow = 1'b0; lat = 0;
  endtask

  task automatic t_base_change();
    base_addr = 32'h0030_0000;
    mem[dir_ea(base_addr, VA1)] = {20'h00600, 12'h001};
    mem[tbl_ea(20'h00600, VA1)] = {20'h13579, 12'h001};
    pulse_flush();
    translate(VA1);
    chk("R11 reads", g_reads, 2);
    chk("R11 new dir addr", rd_log[(rd_count-2) % 4], 32'h0030_0000 + {20'h0, VA1[31:22], 2'b00});
    chk("R11 paddr", g_pa, 32'h1357_9678);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss_walk();
    t_hit();
    t_dir_fault();
    t_tbl_fault();
    t_flush();
    t_rr();
    t_backpressure();
    t_base_change();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule